// File: doc/BRIEF.md
# DMA Stream Priority Arbiter

This block decides which of up to eight DMA streams owns the system bus next. Every stream picks one of eight peripheral request lines through its own 3-bit select field, and it competes only while its enable bit is set and that selected line is high. Among the competing streams, the block grants the one with the highest 2-bit software level. When several streams share the top level, the lowest stream index wins.

A grant is registered. It stays on the same stream until that stream raises its beat-or-burst-done input. An arbitration decision is made only when no grant is held, or on the clock edge where the held stream signals done. In the second case the next winner is loaded on that same edge, so there is no idle cycle between two transfers. The outputs are a one-hot grant vector, the encoded winner index and a valid flag. The bus transfers themselves are handled elsewhere.

Top module: `dmaStreamArbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, grantValid is 0, grantVec is all zeros and grantIdx is 0.
- R2: Stream i is eligible only when streamEnable[i] is 1 and periphReq[reqSelect[3i+2:3i]] is 1. A stream that is disabled, or whose selected line is low, is never newly granted.
- R3: At an arbitration, the eligible stream whose level field prioLevel[2i+1:2i] is numerically highest is granted. The values are 3 = very high, 2 = high, 1 = medium and 0 = low.
- R4: When several eligible streams share the highest level, the stream with the lowest index is granted.
- R5: Once granted, a stream keeps the grant until beatDone[grantIdx] is sampled high. Done pulses from any other stream have no effect on the grant.
- R6: A change to a level field while a grant is held does not change the grant. The new level is used at the next arbitration.
- R7: If no stream is eligible at an arbitration, the next cycle shows grantValid 0, grantVec all zeros and grantIdx 0.
- R8: grantVec has at most one bit set. grantValid equals the OR of grantVec. When grantValid is 1, bit grantIdx of grantVec is set.
- R9: An arbitration takes place on every clock edge where no grant is held, and on the edge where the held stream's done is high. Its result is visible right after that edge, so transfers can follow each other back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periphReq | input | 8 | Peripheral request lines |
| streamEnable | input | 8 | Per-stream enable |
| reqSelect | input | 24 | Per-stream 3-bit request-line select; stream i uses bits [3i+2:3i] |
| prioLevel | input | 16 | Per-stream 2-bit level; stream i uses bits [2i+1:2i] |
| beatDone | input | 8 | Per-stream end of beat or burst |
| grantVec | output | 8 | One-hot grant |
| grantIdx | output | 3 | Index of the granted stream |
| grantValid | output | 1 | A grant is held |

## Verification
The assertions check the following on every cycle:
- The grant vector is one-hot or empty, and it agrees with the valid flag and the index.
- A held grant does not move until the held stream signals done.
- A newly loaded grant belongs to a stream that was eligible when it was chosen.
- An empty arbitration leaves the outputs idle.

The choice itself cannot be judged cycle by cycle from the outputs alone: which stream should have won among the levels, the tie to the lowest index, request routing through each select field, and the deferred effect of level changes. These are shown by the bench scenarios and by a behavioural model that is compared on every clock.

// File: rtl/dmaArbPkg.sv
package dmaArbPkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HOLD = 1'b1
  } arbStateT;

  typedef struct packed {
    logic capture;
    logic clear;
  } arbStrobeT;
endpackage

// File: rtl/arbDatapath.sv
module arbDatapath
  import dmaArbPkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_LINES   = 8,
  parameter int LVL_W       = 2,
  localparam int SEL_W      = $clog2(NUM_LINES),
  localparam int IDX_W      = $clog2(NUM_STREAMS),
  localparam int NUM_LVL    = 1 << LVL_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_LINES-1:0]         periphReq,
  input  logic [NUM_STREAMS-1:0]       streamEnable,
  input  logic [NUM_STREAMS*SEL_W-1:0] reqSelect,
  input  logic [NUM_STREAMS*LVL_W-1:0] prioLevel,
  input  logic [NUM_STREAMS-1:0]       beatDone,
  input  arbStrobeT                    strobe,
  input  logic                         grantValid,
  output logic                         anyEligible,
  output logic                         heldDone,
  output logic [NUM_STREAMS-1:0]       grantVec,
  output logic [IDX_W-1:0]             grantIdx
);
  logic [NUM_STREAMS-1:0] eligibleVec;
  logic [NUM_STREAMS-1:0] candVec;
  logic [NUM_STREAMS-1:0] winVec;
  logic [IDX_W-1:0]       winIdx;
  logic [LVL_W-1:0]       topLvl;

  // Per-stream request multiplexer.
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : gReqMux
    logic [SEL_W-1:0] selLine;
    assign selLine        = reqSelect[s*SEL_W +: SEL_W];
    assign eligibleVec[s] = streamEnable[s] & periphReq[selLine];
  end

  assign anyEligible = |eligibleVec;
  assign heldDone    = |(grantVec & beatDone);

  // Find the highest level with at least one eligible stream.
  always_comb begin
    topLvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      for (int s = 0; s < NUM_STREAMS; s++) begin
        if (eligibleVec[s] && (prioLevel[s*LVL_W +: LVL_W] == LVL_W'(l)))
          topLvl = LVL_W'(l);
      end
    end
  end

  // Keep the streams at that level, then take the lowest index.
  always_comb begin
    for (int s = 0; s < NUM_STREAMS; s++)
      candVec[s] = eligibleVec[s] && (prioLevel[s*LVL_W +: LVL_W] == topLvl);
    winVec = candVec & (~candVec + NUM_STREAMS'(1));
    winIdx = '0;
    for (int s = NUM_STREAMS - 1; s >= 0; s--)
      if (winVec[s]) winIdx = IDX_W'(s);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantVec <= '0;
      grantIdx <= '0;
    end else if (strobe.capture) begin
      grantVec <= winVec;
      grantIdx <= winIdx;
    end else if (strobe.clear) begin
      grantVec <= '0;
      grantIdx <= '0;
    end
  end

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));
  assert_valid_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (|grantVec));
  assert_idx_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> grantVec[grantIdx]);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !beatDone[grantIdx]) |=> $stable(grantVec));
  assert_eligible_win_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (|(grantVec & $past(eligibleVec))));
endmodule

// File: rtl/arbControl.sv
module arbControl
  import dmaArbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyEligible,
  input  logic      heldDone,
  output arbStrobeT strobe,
  output logic      grantValid
);
  arbStateT state;
  logic     arbitrate;

  assign arbitrate      = (state == ARB_IDLE) || heldDone;
  assign strobe.capture = arbitrate && anyEligible;
  assign strobe.clear   = arbitrate && !anyEligible;
  assign grantValid     = (state == ARB_HOLD);

  always_ff @(posedge clk) begin
    if (!rstN)              state <= ARB_IDLE;
    else if (strobe.capture) state <= ARB_HOLD;
    else if (strobe.clear)   state <= ARB_IDLE;
  end

  assert_keep_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ARB_HOLD && !heldDone) |=> state == ARB_HOLD);
  assert_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !grantValid);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capture && strobe.clear));
endmodule

// File: rtl/dmaStreamArbiter.sv
module dmaStreamArbiter
  import dmaArbPkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_LINES   = 8,
  parameter int LVL_W       = 2,
  localparam int SEL_W      = $clog2(NUM_LINES),
  localparam int IDX_W      = $clog2(NUM_STREAMS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_LINES-1:0]         periphReq,
  input  logic [NUM_STREAMS-1:0]       streamEnable,
  input  logic [NUM_STREAMS*SEL_W-1:0] reqSelect,
  input  logic [NUM_STREAMS*LVL_W-1:0] prioLevel,
  input  logic [NUM_STREAMS-1:0]       beatDone,
  output logic [NUM_STREAMS-1:0]       grantVec,
  output logic [IDX_W-1:0]             grantIdx,
  output logic                         grantValid
);
  arbStrobeT strobe;
  logic      anyEligible;
  logic      heldDone;

  arbControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .anyEligible(anyEligible),
    .heldDone   (heldDone),
    .strobe     (strobe),
    .grantValid (grantValid)
  );

  arbDatapath #(
    .NUM_STREAMS(NUM_STREAMS),
    .NUM_LINES  (NUM_LINES),
    .LVL_W      (LVL_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .periphReq   (periphReq),
    .streamEnable(streamEnable),
    .reqSelect   (reqSelect),
    .prioLevel   (prioLevel),
    .beatDone    (beatDone),
    .strobe      (strobe),
    .grantValid  (grantValid),
    .anyEligible (anyEligible),
    .heldDone    (heldDone),
    .grantVec    (grantVec),
    .grantIdx    (grantIdx)
  );
endmodule

// File: tb/sim_dmaStreamArbiter.sv
`timescale 1ns/1ps
module sim_dmaStreamArbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  periphReq = '0;
  logic [7:0]  streamEnable = '0;
  logic [23:0] reqSelect = '0;
  logic [15:0] prioLevel = '0;
  logic [7:0]  beatDone = '0;
  logic [7:0]  grantVec;
  logic [2:0]  grantIdx;
  logic        grantValid;

  int checkCount = 0;
  int failCount  = 0;
  int expValid   = 0;
  int expIdx     = 0;

  always #2.5 clk = ~clk;

  dmaStreamArbiter u0 (
    .clk(clk), .rstN(rstN), .periphReq(periphReq), .streamEnable(streamEnable),
    .reqSelect(reqSelect), .prioLevel(prioLevel), .beatDone(beatDone),
    .grantVec(grantVec), .grantIdx(grantIdx), .grantValid(grantValid)
  );

  task automatic setSel(input int s, input int line);
    reqSelect[s*3 +: 3] = 3'(line);
  endtask

  task automatic setLvl(input int s, input int lvl);
    prioLevel[s*2 +: 2] = 2'(lvl);
  endtask

  task automatic check(input string tag, input int act, input int exp, input string what);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: choose the winner by scanning the streams.
  task automatic modelEdge();
    int best, win;
    if (expValid == 0 || beatDone[expIdx]) begin
      best = -1; win = -1;
      for (int s = 0; s < 8; s++) begin
        int line = int'(reqSelect[s*3 +: 3]);
        int lvl  = int'(prioLevel[s*2 +: 2]);
        if (streamEnable[s] && periphReq[line] && lvl > best) begin
          best = lvl; win = s;
        end
      end
      expValid = (win >= 0) ? 1 : 0;
      expIdx   = (win >= 0) ? win : 0;
    end
  endtask

  task automatic compareOut(input string tag);
    int expVec = (expValid != 0) ? (1 << expIdx) : 0;
    check(tag, int'(grantValid), expValid, "grantValid");
    check(tag, int'(grantIdx), expIdx, "grantIdx");
    check(tag, int'(grantVec), expVec, "grantVec");
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareOut(tag);
  endtask

  task automatic pulseDone(input int s, input string tag);
    beatDone[s] = 1'b1;
    step(tag);
    beatDone = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    checkCount++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    for (int s = 0; s < 8; s++) setSel(s, s);
    repeat (3) @(negedge clk);
    compareOut("R1");
    rstN = 1'b1;
    step("R1");

    // R7: nothing is eligible
    streamEnable = 8'hFF;
    step("R7"); step("R7");

    // R2: routing through the select field, and the enable gate
    setSel(2, 5);
    periphReq = 8'h20;               // line 5: streams 2 and 5
    step("R2");
    check("R2", int'(grantIdx), 2, "routed winner");
    pulseDone(2, "R2");
    streamEnable[2] = 1'b0;
    pulseDone(2, "R2");
    check("R2", int'(grantIdx), 5, "disabled stream skipped");
    streamEnable = '0;
    pulseDone(5, "R2");
    step("R2");
    check("R2", int'(grantValid), 0, "all disabled");

    // R3: level decides
    streamEnable = 8'hFF;
    for (int s = 0; s < 8; s++) setSel(s, s);
    setLvl(1, 1); setLvl(4, 3); setLvl(6, 2);
    periphReq = 8'h53;               // streams 0,1,4,6
    step("R3");
    check("R3", int'(grantIdx), 4, "very high wins");
    pulseDone(4, "R3");
    periphReq = 8'h43;
    pulseDone(4, "R3");
    check("R3", int'(grantIdx), 6, "high next");

    // R4: tie goes to the lower index
    prioLevel = '0;
    setLvl(3, 2); setLvl(5, 2); setLvl(7, 2);
    periphReq = 8'hA8;
    pulseDone(6, "R4");
    check("R4", int'(grantIdx), 3, "lowest index at top level");

    // R5: hold; foreign done pulses are ignored
    setLvl(7, 3);
    step("R5"); step("R5");
    check("R5", int'(grantIdx), 3, "held despite higher request");
    pulseDone(7, "R5");
    check("R5", int'(grantIdx), 3, "foreign done ignored");

    // R6: level change during hold
    setLvl(3, 0); setLvl(5, 3); setLvl(7, 0);
    step("R6");
    check("R6", int'(grantIdx), 3, "level change deferred");
    pulseDone(3, "R6");
    check("R6", int'(grantIdx), 5, "new level used");

    // R9: back to back with no gap
    pulseDone(5, "R9");
    check("R9", int'(grantValid), 1, "no idle cycle");
    pulseDone(int'(grantIdx), "R9");
    periphReq = '0;
    pulseDone(int'(grantIdx), "R7");
    check("R7", int'(grantValid), 0, "empty after last done");

    // R8: random traffic
    for (int n = 0; n < 600; n++) begin
      periphReq    = 8'($urandom);
      streamEnable = 8'($urandom) | 8'h11;
      prioLevel    = 16'($urandom);
      if (n % 7 == 0) reqSelect = 24'($urandom);
      beatDone     = 8'($urandom) & 8'($urandom);
      step("R8");
    end

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule